// File: doc/BRIEF.md
# Bus Ownership Handshake Arbiter

This block sits on the processor side of a single-master system bus and decides when the processor must step off the bus for another device. Three active-low wires carry the exchange: a request from the outside device, a grant from the arbiter, and a grant-acknowledge from whichever device has taken the bus. The arbiter grants a pending request only at the boundary of a processor bus cycle. It then waits for the acknowledge, keeps the processor off the bus while that acknowledge is held, and on release either hands the bus straight to the next requester or gives it back to the processor.

The grant can be asserted again while the current owner still holds acknowledge. An outside arbiter can then choose the next owner before the present one lets go. Request and acknowledge come from another clock domain, so both pass through a chain of flip-flops before any decision uses them. The reset input is asserted asynchronously and released through the same kind of chain.

Top module: `bus_own_arbiter`

## Requirements
- R1: While reset is asserted, and on the first sampling point after it is applied, grant_n_o is 1 and cpu_bus_en_o is 1. The processor owns the bus.
- R2: With the default SYNC_STAGES of 2, a request that is driven low before a rising edge shows on grant_n_o only after the third rising edge. At the sampling point after the second edge, grant_n_o is still 1.
- R3: While the processor owns the bus, a pending request produces no grant as long as cyc_done_i is 0. The grant is issued only at an edge where cyc_done_i is 1.
- R4: When a request is granted, grant_n_o goes to 0 and cpu_bus_en_o goes to 0 on the same edge. The two outputs are never 0 and 1 at the same time.
- R5: Once acknowledge is seen low, grant_n_o returns to 1 (if no other request is pending). cpu_bus_en_o stays 0 for as long as acknowledge is held low.
- R6: A request that is low while acknowledge is still held low causes grant_n_o to go to 0 again before the owner releases the bus.
- R7: If request is low when acknowledge rises, grant_n_o is 0 and cpu_bus_en_o stays 0. The processor does not get the bus back in between.
- R8: If no request is pending when acknowledge rises, cpu_bus_en_o returns to 1 and grant_n_o is 1, whatever the value of cyc_done_i.
- R9: If request is withdrawn before any acknowledge arrives, grant_n_o returns to 1 and cpu_bus_en_o returns to 1.
- R10: If an early re-grant made while acknowledge is held has its request withdrawn, grant_n_o returns to 1 and cpu_bus_en_o stays 0 while acknowledge is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n_i | input | 1 | Bus request from an outside device, active low, asynchronous |
| ack_n_i | input | 1 | Grant-acknowledge from the owning device, active low, asynchronous |
| cyc_done_i | input | 1 | High when the processor is at a bus-cycle boundary |
| grant_n_o | output | 1 | Bus grant, active low |
| cpu_bus_en_o | output | 1 | High while the processor may run bus cycles |

## Verification
Every change on req_n_i or ack_n_i takes two edges to cross the synchronizer and one more edge to move the state register. The outputs are decoded directly from that state, so each result is due after the third rising edge. A dedicated test samples grant_n_o at the falling edge after edge two and again after edge three, which pins that latency down exactly. The table walk holds each input vector for four edges and compares at the following falling edge. Every transition has settled by then, and sampling away from the edge avoids any race. The reset checks sample one time unit after reset is applied, because reset acts asynchronously and is due at once.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    ST_CPU   = 2'd0,  // processor owns the bus
    ST_GRANT = 2'd1,  // grant out, waiting for acknowledge
    ST_OWNED = 2'd2,  // outside master holds acknowledge
    ST_PEND  = 2'd3   // acknowledge held, next master already granted
  } bo_state_e;
endpackage

// File: rtl/bo_sync.sv
module bo_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  // next value of every stage: stage 0 takes the input, others shift
  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[LAST];
endmodule

// File: rtl/bo_fsm.sv
module bo_fsm
  import bo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_s,
  input  logic      ack_s,
  input  logic      cyc_done,
  output bo_state_e state_o,
  output logic      grant_n_o,
  output logic      cpu_bus_en_o
);
  bo_state_e st_q, st_d;
  logic      st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CPU:   if (req_s && cyc_done) st_d = ST_GRANT;
      ST_GRANT: begin
        if (ack_s)       st_d = ST_OWNED;
        else if (!req_s) st_d = ST_CPU;
      end
      ST_OWNED: begin
        if (!ack_s)     st_d = req_s ? ST_GRANT : ST_CPU;
        else if (req_s) st_d = ST_PEND;
      end
      ST_PEND: begin
        if (!ack_s)      st_d = req_s ? ST_GRANT : ST_CPU;
        else if (!req_s) st_d = ST_OWNED;
      end
      default: st_d = ST_CPU;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_CPU;
    else if (st_en) st_q <= st_d;
  end

  assign state_o      = st_q;
  assign grant_n_o    = !((st_q == ST_GRANT) || (st_q == ST_PEND));
  assign cpu_bus_en_o = (st_q == ST_CPU);
endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter
  import bo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic ack_n_i,
  input  logic cyc_done_i,
  output logic grant_n_o,
  output logic cpu_bus_en_o
);
  localparam int unsigned PINS = 2;

  logic            rst_sync_n;
  logic [PINS-1:0] pins_s;
  logic            req_s;
  logic            ack_s;
  bo_state_e       state;

  // reset: asserted at once, released after SYNC_STAGES edges
  bo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // arbitration pins, idle high
  bo_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL({PINS{1'b1}})) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({req_n_i, ack_n_i}),
    .q     (pins_s)
  );

  assign req_s = !pins_s[1];
  assign ack_s = !pins_s[0];

  bo_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_s        (req_s),
    .ack_s        (ack_s),
    .cyc_done     (cyc_done_i),
    .state_o      (state),
    .grant_n_o    (grant_n_o),
    .cpu_bus_en_o (cpu_bus_en_o)
  );
endmodule

// File: rtl/bo_checker.sv
module bo_checker
  import bo_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      grant_n,
  input logic      cpu_en,
  input logic      req_s,
  input logic      ack_s,
  input logic      cyc_done,
  input bo_state_e state
);
  // a grant issued while the processor owned the bus needs a cycle boundary
  assert_grant_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(grant_n) && $past(cpu_en)) |-> $past(cyc_done));

  // grant and processor ownership exclude each other
  assert_grant_excludes_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n |-> !cpu_en);

  // an outside owner keeps the processor off the bus
  assert_ack_holds_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_s && !cpu_en) |=> !cpu_en);

  // a request during ownership brings the grant back early
  assert_early_regrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWNED && ack_s && req_s) |=> !grant_n);

  // release with a pending request goes straight to a new grant
  assert_direct_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_OWNED || state == ST_PEND) && !ack_s && req_s) |=> (!grant_n && !cpu_en));

  // the processor resumes only when nobody requests or owns the bus
  assert_resume_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_en) |-> $past(!req_s && !ack_s));
endmodule

bind bus_own_arbiter bo_checker u_bo_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant_n  (grant_n_o),
  .cpu_en   (cpu_bus_en_o),
  .req_s    (req_s),
  .ack_s    (ack_s),
  .cyc_done (cyc_done_i),
  .state    (state)
);

// File: tb/bus_own_arbiter_bench.sv
module bus_own_arbiter_bench;
  localparam int NVEC = 18;
  // {req_n, ack_n, cyc_done, expected grant_n, expected cpu_bus_en}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b111_11,  // 0  R1 idle
    5'b010_11,  // 1  R3 request, cycle busy
    5'b010_11,  // 2  R3 still busy
    5'b011_00,  // 3  R4 boundary -> grant
    5'b101_10,  // 4  R5 acknowledged, request dropped
    5'b001_00,  // 5  R6 next request while owned
    5'b011_00,  // 6  R7 release with request held
    5'b101_10,  // 7  R5 new owner
    5'b111_11,  // 8  R8 release, processor back
    5'b011_00,  // 9  R4 grant
    5'b111_11,  // 10 R9 withdrawn before acknowledge
    5'b011_00,  // 11 R4 grant
    5'b101_10,  // 12 R5 owned
    5'b001_00,  // 13 R6 early re-grant
    5'b101_10,  // 14 R10 early request withdrawn
    5'b011_00,  // 15 R7 release and new request together
    5'b100_10,  // 16 R5 owned, cycle flag low
    5'b110_11   // 17 R8 release with cycle flag low
  };

  function automatic string vec_tag(int i);
    case (i)
      0:               return "R1";
      1, 2:            return "R3";
      3, 9, 11:        return "R4";
      4, 7, 12, 16:    return "R5";
      5, 13:           return "R6";
      6, 15:           return "R7";
      8, 17:           return "R8";
      10:              return "R9";
      default:         return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic ack_n = 1'b1;
  logic cyc_done = 1'b1;
  logic grant_n;
  logic cpu_en;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #4 clk = !clk;

  bus_own_arbiter u_bus_own_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_n_i      (req_n),
    .ack_n_i      (ack_n),
    .cyc_done_i   (cyc_done),
    .grant_n_o    (grant_n),
    .cpu_bus_en_o (cpu_en)
  );

  task automatic check(string tag, logic exp_g, logic exp_c);
    checks++;
    if (grant_n !== exp_g || cpu_en !== exp_c) begin
      errors++;
      $display("FAIL %s: grant_n=%b cpu_bus_en=%b, expected grant_n=%b cpu_bus_en=%b",
               tag, grant_n, cpu_en, exp_g, exp_c);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 1'b1, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: three-edge latency from request to grant
    @(negedge clk);
    req_n = 1'b0;
    cyc_done = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 after two edges", 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R2 after three edges", 1'b0, 1'b0);
    req_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 withdrawn after latency test", 1'b1, 1'b1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      req_n    = VEC[i][4];
      ack_n    = VEC[i][3];
      cyc_done = VEC[i][2];
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(vec_tag(i), VEC[i][1], VEC[i][0]);
    end

    // R3: long busy cycle, grant only after the flag rises
    req_n = 1'b0;
    cyc_done = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R3 held off 20 cycles", 1'b1, 1'b1);
    cyc_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 grant at boundary", 1'b0, 1'b0);

    // R1: reset applied while granted acts at once
    rst_n = 1'b0;
    #1;
    check("R1 reset while granted", 1'b1, 1'b1);
    req_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after second reset", 1'b1, 1'b1);

    report();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end
endmodule